// File: doc/BRIEF.md
# Conditional Add Execute Unit

This block is the execute stage for the two's-complement add instruction of a small 8-bit processor. Each cycle it may receive one decoded operation: an add, a prefix, or nothing. For an add, the decoder supplies the source form, the condition field, the immediate bits, the value read for the register source, the destination index and the value read for the destination. The block tests the condition against its own Carry, Sign and Zero flags and a small set of external status bits. It then adds source, destination and carry-in, writes the result back, updates the flags, and asks the fetch stage to redirect when the destination is the program counter.

A prefix operation arms a one-shot state for the add that follows it. That state can name a different write destination. It can also load the carry-in from any condition, optionally inverted. The carry-in is zero when no prefix is pending. The result path and the redirect are registered, so the write and the new fetch address appear in the cycle after the add is presented. The fetch stage uses the one-cycle `redirect` pulse to drop the instruction it has already fetched.

Top module: `cadd_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `wr_en`=0, `redirect`=0 and all three flags 0, and any pending prefix is discarded.
- R2: An add whose condition passes produces, one cycle later, `wr_data` = (source + destination value + carry-in) mod 256 and `wr_idx` = destination index, with `wr_en`=1 for that single cycle. Only an add (`op_kind`=1) can raise `wr_en`.
- R3: The source is `sri_val` when `src_form`=0 (register form). It is `imm[3:0]` sign-extended to 8 bits when `src_form`=1 (short form). It is `imm` when `src_form`=2 (byte form). The byte form is unconditional.
- R4: The condition selector picks one of eight values: 0 true, 1 Zero, 2 Carry, 3 Sign, and 4 to 7 `ext_bits[0]` to `ext_bits[3]`. The picked value is XORed with `cond_neg`. The register form uses all 3 bits of `cond_sel`. The short form uses only `cond_sel[1:0]`, with the top bit taken as 0.
- R5: An add whose condition fails leaves `wr_en` and `redirect` low and all flags unchanged. A cycle with no add also leaves the flags unchanged.
- R6: When an add passes, the flags are updated as follows. Carry is the carry out of bit 7 of the sum. Sign is bit 7 of the result. Zero is set exactly when the 8-bit result is 0.
- R7: A prefix (`op_kind`=2) with `pf_dst_en`=1 makes the next add write to `pf_dst_idx` instead of `dst_idx`. The destination operand is still `dst_val`.
- R8: The carry-in is 0 unless a prefix is pending. A prefix sets the carry-in to the condition picked by `pf_cin_sel`, XORed with `pf_cin_inv`. The condition is evaluated with the flags and `ext_bits` of the prefix cycle, using the selector codes of R4.
- R9: A pending prefix is used by the next add and then cleared, whether or not that add's condition passes. Idle cycles do not clear it, and a newer prefix replaces it.
- R10: A passing add whose effective destination is index 7 (the program counter) does not write. One cycle later it raises `redirect` for exactly one cycle, with `redirect_addr` = the sum.
- R11: A prefix that sets the carry-in from `ext_bits[0]` and is followed by adding a register to itself produces that value shifted left by one, with `ext_bits[0]` in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_kind | input | 2 | 0 idle, 1 add, 2 prefix |
| src_form | input | 2 | 0 register, 1 short immediate, 2 byte immediate |
| cond_neg | input | 1 | Invert the add condition |
| cond_sel | input | 3 | Add condition selector |
| imm | input | 8 | Immediate bits |
| sri_val | input | 8 | Register source value |
| dst_idx | input | 3 | Destination register index |
| dst_val | input | 8 | Destination register value |
| pf_dst_en | input | 1 | Prefix overrides the write destination |
| pf_dst_idx | input | 3 | Prefix write destination |
| pf_cin_inv | input | 1 | Invert the carry preload condition |
| pf_cin_sel | input | 3 | Carry preload condition selector |
| ext_bits | input | 4 | External condition bits |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 3 | Register write index |
| wr_data | output | 8 | Register write value |
| flag_c | output | 1 | Carry flag |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| redirect | output | 1 | Fetch redirect and flush pulse |
| redirect_addr | output | 8 | New fetch address |

## Verification
The hardest situations to reach are those where a condition depends on a flag value the block itself computed. The worst of these is a prefix consumed by an add whose condition fails, because that add leaves no visible result. The bench first runs an add with operands chosen to put the flags into a known state. It then issues the conditional add or prefix under test, sweeping every selector, inversion and external bit pattern. After a failed-condition add it follows with an always-true add, so a prefix that was not cleared would show up as a wrong index or an extra carry. The shift-left case is swept over many register values with both values of the external bit.

// File: rtl/cadd_pkg.sv
package cadd_pkg;
    localparam int DW          = 8;
    localparam int RIW         = 3;
    localparam int EXTW        = 4;
    localparam int CSW         = 3;
    localparam int SHORT_CSW   = 2;
    localparam int IMM_SHORT_W = 4;
    localparam int NSEL        = 2 ** CSW;

    localparam logic [RIW-1:0] PC_IDX = '1;

    localparam int CS_TRUE     = 0;
    localparam int CS_Z        = 1;
    localparam int CS_C        = 2;
    localparam int CS_S        = 3;
    localparam int CS_BIT_BASE = 4;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_ADD    = 2'd1,
        OP_PREFIX = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        SRC_REG  = 2'd0,
        SRC_IMM4 = 2'd1,
        SRC_IMM8 = 2'd2
    } form_e;

    typedef struct packed {
        logic c;
        logic s;
        logic z;
    } flags_t;

    typedef struct packed {
        logic           pend;
        logic           dst_en;
        logic [RIW-1:0] dst_idx;
        logic           cin;
    } prefix_t;

    function automatic logic [DW-1:0] sext_short(input logic [IMM_SHORT_W-1:0] v);
        return {{(DW-IMM_SHORT_W){v[IMM_SHORT_W-1]}}, v};
    endfunction
endpackage

// File: rtl/cadd_cond_eval.sv
module cadd_cond_eval
    import cadd_pkg::*;
(
    input  logic [CSW-1:0]  sel,
    input  logic            neg,
    input  flags_t          flags,
    input  logic [EXTW-1:0] ext,
    output logic            hit
);
    logic [NSEL-1:0] srcs;

    always_comb begin
        srcs          = '0;
        srcs[CS_TRUE] = 1'b1;
        srcs[CS_Z]    = flags.z;
        srcs[CS_C]    = flags.c;
        srcs[CS_S]    = flags.s;
        for (int i = 0; i < EXTW; i++) begin
            srcs[CS_BIT_BASE + i] = ext[i];
        end
    end

    assign hit = srcs[sel] ^ neg;
endmodule

// File: rtl/cadd_adder.sv
module cadd_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] wide;
    assign wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    assign sum  = wide[W-1:0];
    assign cout = wide[W];
endmodule

// File: rtl/cadd_prefix_reg.sv
module cadd_prefix_reg
    import cadd_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           consume,
    input  logic           dst_en,
    input  logic [RIW-1:0] dst_idx,
    input  logic           cin,
    output prefix_t        state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (load) begin
            state.pend    <= 1'b1;
            state.dst_en  <= dst_en;
            state.dst_idx <= dst_idx;
            state.cin     <= cin;
        end else if (consume) begin
            state <= '0;
        end
    end
endmodule

// File: rtl/cadd_exec_unit.sv
module cadd_exec_unit
    import cadd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      op_kind,
    input  logic [1:0]      src_form,
    input  logic            cond_neg,
    input  logic [CSW-1:0]  cond_sel,
    input  logic [DW-1:0]   imm,
    input  logic [DW-1:0]   sri_val,
    input  logic [RIW-1:0]  dst_idx,
    input  logic [DW-1:0]   dst_val,
    input  logic            pf_dst_en,
    input  logic [RIW-1:0]  pf_dst_idx,
    input  logic            pf_cin_inv,
    input  logic [CSW-1:0]  pf_cin_sel,
    input  logic [EXTW-1:0] ext_bits,
    output logic            wr_en,
    output logic [RIW-1:0]  wr_idx,
    output logic [DW-1:0]   wr_data,
    output logic            flag_c,
    output logic            flag_s,
    output logic            flag_z,
    output logic            redirect,
    output logic [DW-1:0]   redirect_addr
);
    flags_t         flags_q;
    prefix_t        pf_q;
    logic           is_add, is_pf, is_imm4, is_imm8;
    logic [CSW-1:0] add_sel;
    logic           add_hit, pf_hit, pass;
    logic [DW-1:0]  src_op, sum;
    logic           cin, cout;
    logic [RIW-1:0] dest;
    logic           dest_pc;

    assign is_add  = (op_kind == OP_ADD);
    assign is_pf   = (op_kind == OP_PREFIX);
    assign is_imm4 = (src_form == SRC_IMM4);
    assign is_imm8 = (src_form == SRC_IMM8);

    // The short form carries a narrower condition field.
    assign add_sel = is_imm4 ? {{(CSW-SHORT_CSW){1'b0}}, cond_sel[SHORT_CSW-1:0]}
                             : cond_sel;

    cadd_cond_eval u_add_cond (
        .sel   (add_sel),
        .neg   (cond_neg),
        .flags (flags_q),
        .ext   (ext_bits),
        .hit   (add_hit)
    );

    cadd_cond_eval u_cin_cond (
        .sel   (pf_cin_sel),
        .neg   (pf_cin_inv),
        .flags (flags_q),
        .ext   (ext_bits),
        .hit   (pf_hit)
    );

    cadd_prefix_reg u_prefix (
        .clk     (clk),
        .rst     (rst),
        .load    (is_pf),
        .consume (is_add),
        .dst_en  (pf_dst_en),
        .dst_idx (pf_dst_idx),
        .cin     (pf_hit),
        .state   (pf_q)
    );

    always_comb begin
        if (is_imm8)      src_op = imm;
        else if (is_imm4) src_op = sext_short(imm[IMM_SHORT_W-1:0]);
        else              src_op = sri_val;
    end

    assign cin     = pf_q.pend & pf_q.cin;
    assign dest    = (pf_q.pend && pf_q.dst_en) ? pf_q.dst_idx : dst_idx;
    assign dest_pc = (dest == PC_IDX);
    assign pass    = is_add && (is_imm8 || add_hit);

    cadd_adder #(.W(DW)) u_adder (
        .a    (src_op),
        .b    (dst_val),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q       <= '0;
            wr_en         <= 1'b0;
            wr_idx        <= '0;
            wr_data       <= '0;
            redirect      <= 1'b0;
            redirect_addr <= '0;
        end else begin
            wr_en         <= pass && !dest_pc;
            redirect      <= pass && dest_pc;
            wr_idx        <= dest;
            wr_data       <= sum;
            redirect_addr <= sum;
            if (pass) begin
                flags_q.c <= cout;
                flags_q.s <= sum[DW-1];
                flags_q.z <= (sum == '0);
            end
        end
    end

    assign flag_c = flags_q.c;
    assign flag_s = flags_q.s;
    assign flag_z = flags_q.z;
endmodule

// File: rtl/cadd_exec_chk.sv
module cadd_exec_chk
    import cadd_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [1:0]    op_kind,
    input logic [1:0]    src_form,
    input logic          wr_en,
    input logic          redirect,
    input logic          flag_c,
    input logic          flag_s,
    input logic          flag_z,
    input logic [DW-1:0] wr_data
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!wr_en && !redirect && !flag_c && !flag_s && !flag_z));

    p_write_needs_add_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($past(op_kind) == OP_ADD));

    p_imm8_always_r3: assert property (@(posedge clk) disable iff (rst)
        (op_kind == OP_ADD && src_form == SRC_IMM8) |=> (wr_en || redirect));

    p_flags_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (op_kind != OP_ADD) |=> $stable({flag_c, flag_s, flag_z}));

    p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (flag_z == (wr_data == '0)));

    p_sign_flag_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (flag_s == wr_data[DW-1]));

    p_redirect_source_r10: assert property (@(posedge clk) disable iff (rst)
        redirect |-> ($past(op_kind) == OP_ADD));

    p_write_redirect_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && redirect));
endmodule

bind cadd_exec_unit cadd_exec_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_kind  (op_kind),
    .src_form (src_form),
    .wr_en    (wr_en),
    .redirect (redirect),
    .flag_c   (flag_c),
    .flag_s   (flag_s),
    .flag_z   (flag_z),
    .wr_data  (wr_data)
);

// File: tb/cadd_exec_unit_tb.sv
module cadd_exec_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] op_kind = '0;
    logic [1:0] src_form = '0;
    logic       cond_neg = 1'b0;
    logic [2:0] cond_sel = '0;
    logic [7:0] imm = '0;
    logic [7:0] sri_val = '0;
    logic [2:0] dst_idx = '0;
    logic [7:0] dst_val = '0;
    logic       pf_dst_en = 1'b0;
    logic [2:0] pf_dst_idx = '0;
    logic       pf_cin_inv = 1'b0;
    logic [2:0] pf_cin_sel = '0;
    logic [3:0] ext_bits = '0;
    logic       wr_en;
    logic [2:0] wr_idx;
    logic [7:0] wr_data;
    logic       flag_c, flag_s, flag_z;
    logic       redirect;
    logic [7:0] redirect_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    logic       mc = 0, ms = 0, mz = 0;
    logic       mpend = 0, mpen = 0, mpcin = 0;
    logic [2:0] mpidx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cadd_exec_unit dut_i (
        .clk(clk), .rst(rst), .op_kind(op_kind), .src_form(src_form),
        .cond_neg(cond_neg), .cond_sel(cond_sel), .imm(imm), .sri_val(sri_val),
        .dst_idx(dst_idx), .dst_val(dst_val), .pf_dst_en(pf_dst_en),
        .pf_dst_idx(pf_dst_idx), .pf_cin_inv(pf_cin_inv), .pf_cin_sel(pf_cin_sel),
        .ext_bits(ext_bits), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .flag_c(flag_c), .flag_s(flag_s), .flag_z(flag_z),
        .redirect(redirect), .redirect_addr(redirect_addr)
    );

    function automatic logic m_cond(input logic [2:0] sel, input logic neg,
                                    input logic [3:0] ext);
        logic v;
        case (sel)
            3'd0:    v = 1'b1;
            3'd1:    v = mz;
            3'd2:    v = mc;
            3'd3:    v = ms;
            default: v = ext[sel - 3'd4];
        endcase
        return v ^ neg;
    endfunction

    // Drive one operation at a falling edge, predict, then check at the next falling edge.
    task automatic step(input logic [1:0] op, input logic [1:0] form, input logic neg,
                        input logic [2:0] sel, input logic [7:0] im, input logic [7:0] sv,
                        input logic [2:0] di, input logic [7:0] dv, input logic pen,
                        input logic [2:0] pidx, input logic pinv, input logic [2:0] psel,
                        input logic [3:0] ext, input string tag, output logic [7:0] res);
        logic       ewr, erd, pass, cin;
        logic [7:0] src;
        logic [2:0] dest;
        logic [8:0] s9;
        op_kind = op; src_form = form; cond_neg = neg; cond_sel = sel; imm = im;
        sri_val = sv; dst_idx = di; dst_val = dv; pf_dst_en = pen; pf_dst_idx = pidx;
        pf_cin_inv = pinv; pf_cin_sel = psel; ext_bits = ext;
        ewr = 0; erd = 0; dest = di; s9 = '0;
        if (op == 2'd1) begin
            if (form == 2'd2)      pass = 1'b1;
            else if (form == 2'd1) pass = m_cond({1'b0, sel[1:0]}, neg, ext);
            else                   pass = m_cond(sel, neg, ext);
            if (form == 2'd2)      src = im;
            else if (form == 2'd1) src = {{4{im[3]}}, im[3:0]};
            else                   src = sv;
            cin  = mpend ? mpcin : 1'b0;
            dest = (mpend && mpen) ? mpidx : di;
            s9   = {1'b0, src} + {1'b0, dv} + {8'd0, cin};
            if (pass) begin
                if (dest == 3'd7) erd = 1'b1;
                else              ewr = 1'b1;
                mc = s9[8]; ms = s9[7]; mz = (s9[7:0] == 8'd0);
            end
            mpend = 1'b0;
        end else if (op == 2'd2) begin
            mpcin = m_cond(psel, pinv, ext);
            mpend = 1'b1; mpen = pen; mpidx = pidx;
        end
        @(negedge clk);
        res = s9[7:0];
        checks++;
        if (wr_en !== ewr || redirect !== erd || {flag_c, flag_s, flag_z} !== {mc, ms, mz} ||
            (ewr && (wr_idx !== dest || wr_data !== s9[7:0])) ||
            (erd && redirect_addr !== s9[7:0])) begin
            fails++;
            $display("FAIL %s: wr_en=%b/%b idx=%0d/%0d data=%h/%h redir=%b/%b addr=%h/%h csz=%b%b%b/%b%b%b",
                     tag, wr_en, ewr, wr_idx, dest, wr_data, s9[7:0], redirect, erd,
                     redirect_addr, s9[7:0], flag_c, flag_s, flag_z, mc, ms, mz);
        end
    endtask

    task automatic add(input logic [1:0] form, input logic neg, input logic [2:0] sel,
                       input logic [7:0] im, input logic [7:0] sv, input logic [2:0] di,
                       input logic [7:0] dv, input logic [3:0] ext, input string tag);
        logic [7:0] r;
        step(2'd1, form, neg, sel, im, sv, di, dv, 1'b0, 3'd0, 1'b0, 3'd0, ext, tag, r);
    endtask

    task automatic prefix(input logic pen, input logic [2:0] pidx, input logic pinv,
                          input logic [2:0] psel, input logic [3:0] ext, input string tag);
        logic [7:0] r;
        step(2'd2, 2'd0, 1'b0, 3'd0, 8'd0, 8'd0, 3'd0, 8'd0, pen, pidx, pinv, psel, ext, tag, r);
    endtask

    task automatic idle(input string tag);
        logic [7:0] r;
        step(2'd0, 2'd0, 1'b0, 3'd0, 8'd0, 8'd0, 3'd0, 8'd0, 1'b0, 3'd0, 1'b0, 3'd0,
             ext_bits, tag, r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (wr_en !== 1'b0 || redirect !== 1'b0 || {flag_c, flag_s, flag_z} !== 3'b000) begin
            fails++;
            $display("FAIL R1: wr_en=%b redir=%b csz=%b%b%b / expected 0 0 000",
                     wr_en, redirect, flag_c, flag_s, flag_z);
        end
        // R1: a prefix armed just before reset must be gone afterwards
        prefix(1'b1, 3'd5, 1'b0, 3'd0, 4'h0, "R1");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        mpend = 0; mc = 0; ms = 0; mz = 0;
        add(2'd0, 1'b0, 3'd0, 8'd0, 8'h10, 3'd2, 8'h20, 4'h0, "R1");

        // R2, R6: register form, always-true condition, operand sweep
        for (int a = 0; a < 256; a += 5) begin
            for (int b = 0; b < 256; b += 11) begin
                add(2'd0, 1'b0, 3'd0, 8'd0, 8'(a), 3'(a % 7), 8'(b), 4'h0, "R2_R6");
            end
        end
        add(2'd0, 1'b0, 3'd0, 8'd0, 8'hFF, 3'd1, 8'h01, 4'h0, "R6");
        add(2'd0, 1'b0, 3'd0, 8'd0, 8'h7F, 3'd1, 8'h01, 4'h0, "R6");

        // R3: short immediate sign extension and byte immediate
        for (int k = 0; k < 16; k++) begin
            for (int b = 0; b < 256; b += 37) begin
                add(2'd1, 1'b0, 3'd0, 8'(k), 8'hAA, 3'd3, 8'(b), 4'h0, "R3");
                add(2'd2, 1'b0, 3'd0, 8'(k * 17), 8'hAA, 3'd4, 8'(b), 4'h0, "R3");
            end
        end
        // R3: byte immediate ignores a never-true condition
        add(2'd2, 1'b1, 3'd0, 8'h23, 8'h00, 3'd2, 8'h10, 4'h0, "R3");

        // R4, R5: every selector and inversion against varied flags and external bits
        for (int k = 0; k < 512; k++) begin
            add(2'd0, 1'b0, 3'd0, 8'd0, 8'(k * 29), 3'd1, 8'(k * 53 + 7), 4'h0, "R4_setup");
            add(2'(k % 2), 1'((k / 8) % 2), 3'(k / 2), 8'(k), 8'(k * 3), 3'(k % 7),
                8'(k * 5), 4'(k / 16), "R4_R5");
            if (k % 5 == 0) idle("R5");
        end

        // R7: destination override, operand still from dst_val
        prefix(1'b1, 3'd6, 1'b1, 3'd0, 4'h0, "R7");
        add(2'd0, 1'b0, 3'd0, 8'd0, 8'h11, 3'd2, 8'h22, 4'h0, "R7");

        // R8: carry preload from each selector, both polarities
        for (int k = 0; k < 64; k++) begin
            add(2'd0, 1'b0, 3'd0, 8'd0, 8'(k * 61), 3'd0, 8'(k * 23), 4'h0, "R8_setup");
            prefix(1'b0, 3'd0, 1'(k % 2), 3'(k / 2), 4'(k * 3), "R8");
            add(2'd0, 1'b0, 3'd0, 8'd0, 8'(k), 3'd3, 8'(k * 7), 4'h0, "R8");
        end

        // R9: prefix consumed by a failing add, idle keeps it, a new prefix replaces it
        prefix(1'b1, 3'd3, 1'b1, 3'd0, 4'h0, "R9");
        add(2'd0, 1'b1, 3'd0, 8'd0, 8'h05, 3'd2, 8'h01, 4'h0, "R9");
        add(2'd0, 1'b0, 3'd0, 8'd0, 8'h05, 3'd2, 8'h01, 4'h0, "R9");
        prefix(1'b1, 3'd4, 1'b1, 3'd0, 4'h0, "R9");
        idle("R9");
        idle("R9");
        add(2'd0, 1'b0, 3'd0, 8'd0, 8'h05, 3'd2, 8'h01, 4'h0, "R9");
        prefix(1'b1, 3'd4, 1'b1, 3'd0, 4'h0, "R9");
        prefix(1'b1, 3'd5, 1'b0, 3'd0, 4'h0, "R9");
        add(2'd0, 1'b0, 3'd0, 8'd0, 8'h05, 3'd2, 8'h01, 4'h0, "R9");

        // R10: program counter destination
        add(2'd2, 1'b0, 3'd0, 8'h07, 8'h00, 3'd7, 8'h40, 4'h0, "R10");
        idle("R10");
        add(2'd1, 1'b0, 3'd0, 8'h0E, 8'h00, 3'd7, 8'h40, 4'h0, "R10");
        add(2'd1, 1'b0, 3'd0, 8'h03, 8'h00, 3'd7, 8'h80, 4'h0, "R10");
        add(2'd0, 1'b1, 3'd0, 8'h00, 8'h01, 3'd7, 8'h80, 4'h0, "R10");
        prefix(1'b1, 3'd7, 1'b0, 3'd0, 4'h0, "R10");
        add(2'd0, 1'b0, 3'd0, 8'd0, 8'h10, 3'd1, 8'h20, 4'h0, "R10");
        idle("R10");

        // R11: shift left through carry with ext_bits[0] as serial input
        for (int v = 0; v < 256; v += 3) begin
            for (int b = 0; b < 2; b++) begin
                logic [7:0] r;
                prefix(1'b1, 3'd1, 1'b0, 3'd4, 4'(b) | 4'b1010, "R11");
                step(2'd1, 2'd0, 1'b0, 3'd0, 8'd0, 8'(v), 3'd1, 8'(v), 1'b0, 3'd0,
                     1'b0, 3'd0, 4'h0, "R11", r);
                checks++;
                if (wr_data !== {8'(v) << 1} + 8'(b) || wr_en !== 1'b1) begin
                    fails++;
                    $display("FAIL R11: data=%h expected=%h", wr_data, 8'((v << 1) + b));
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
    end
endmodule